// File: doc/BRIEF.md
# Latched Fault Supervisor for a Switching Controller

This block sequences the protection faults of a flyback power controller. It takes already-digitised comparator flags (sense over the current limit, supply below the short-circuit level, supply over-voltage, feedback pinned at its open-loop level, and two thermistor thresholds) and qualifies each flag with its own debounce counter. When a counter completes, a shared latch turns the PWM off and records the cause as a one-hot code. The latch and the code are cleared together only when the supply collapses to its release level. The block also applies start and stop hysteresis to the supply, so the PWM runs only between a start event and a stop event.

The overcurrent path has two outcomes. A single counter runs while the sense flag stays high. At one fixed count the supply-low flag is sampled once. If the supply is low at that point, the short-circuit fault latches. If it is not, counting continues to a much longer overcurrent limit. Both thermistor thresholds have debounce limits that depend on the mode: one limit in normal load and a longer one while the green-mode flag is high. All limits are counted in clock cycles and set by parameters.

Top module: `fault_supervisor`

## Requirements
- R1: While reset is asserted, pwmEnable, faultLatched and faultCode are all 0.
- R2: A run flag sets on the edge after vddAboveStart is sampled high while stopped, and clears on the edge after vddBelowStop is sampled high while running. The flag holds between these events. pwmEnable is the run flag while no fault is latched.
- R3: If senseOverLimit is sampled high on SCP_CYC consecutive enabled edges and vddBelowScp is high on the last of them, the latch sets with faultCode bit 0.
- R4: If vddBelowScp is low on that one check edge, the sense count continues. Once senseOverLimit has been high for OCP_CYC consecutive enabled edges, the latch sets with faultCode bit 1. vddBelowScp on any other edge has no effect.
- R5: Any fault flag that drops before its limit restarts its count from zero.
- R6: fbOpenLoop high for OLP_CYC consecutive enabled edges latches faultCode bit 2.
- R7: vddOverVolt high for OVP_CYC consecutive enabled edges latches faultCode bit 3.
- R8: rtBelowWarm high with rtBelowHot low latches faultCode bit 4 once the consecutive count reaches WARM_NORM_CYC (greenMode 0) or WARM_GREEN_CYC (greenMode 1). The limit is chosen by the current greenMode, so a drop to the shorter limit fires at once if the count is already past it.
- R9: rtBelowHot high latches faultCode bit 5 after HOT_NORM_CYC or HOT_GREEN_CYC consecutive enabled edges, chosen the same way.
- R10: While latched, pwmEnable is 0, faultCode stays one-hot and unchanged, and new fault flags have no effect.
- R11: vddBelowRelease sampled high while latched clears faultLatched and faultCode on the next edge. Sampled while not latched, it has no effect.
- R12: When several faults complete on the same edge, one code bit is recorded, with priority OVP > hot > SCP > OCP > OLP > warm.
- R13: While the run flag is clear, no count advances and no fault latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| senseOverLimit | input | 1 | Current sense above the cycle limit |
| vddBelowScp | input | 1 | Supply below the short-circuit decision level |
| vddOverVolt | input | 1 | Supply above the over-voltage level |
| fbOpenLoop | input | 1 | Feedback above the open-loop level |
| rtBelowWarm | input | 1 | Thermistor voltage below the first threshold |
| rtBelowHot | input | 1 | Thermistor voltage below the second, lower threshold |
| vddAboveStart | input | 1 | Supply above the start level |
| vddBelowStop | input | 1 | Supply below the stop level |
| vddBelowRelease | input | 1 | Supply below the latch release level |
| greenMode | input | 1 | Light-load mode, selects the longer thermal limits |
| pwmEnable | output | 1 | PWM allowed |
| faultLatched | output | 1 | Protection latch set |
| faultCode | output | 6 | One-hot cause: bit0 SCP, 1 OCP, 2 OLP, 3 OVP, 4 warm, 5 hot |

## Verification
The hardest case to reach is the single-edge short-circuit decision. The supply-low flag must be absent on exactly the check edge but present on the edges around it, and only then does the count reach the long overcurrent limit. The stimulus holds vddBelowScp high throughout, drops it for one cycle aligned to the check edge, and confirms that the latch stays clear until the overcurrent limit. A second hard case is a mode switch mid-count. The thermal flag runs past the normal limit under green mode, then greenMode falls, and the latch must set on the very next edge. Simultaneous completions are arranged by matching limits (short-circuit with hot green, overcurrent with open-loop) to check the priority.

// File: rtl/fault_supervisor_pkg.sv
package fault_supervisor_pkg;

  localparam int NUM_FAULTS = 6;
  localparam int IDX_SCP  = 0;
  localparam int IDX_OCP  = 1;
  localparam int IDX_OLP  = 2;
  localparam int IDX_OVP  = 3;
  localparam int IDX_WARM = 4;
  localparam int IDX_HOT  = 5;

  typedef logic [NUM_FAULTS-1:0] faultVec_t;

  // control -> datapath strobes
  typedef struct packed {
    logic countEn;   // running and not latched
    logic greenSel;  // use the light-load thermal limits
  } dpStrobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // fixed priority: OVP, hot, SCP, OCP, OLP, warm
  function automatic faultVec_t pickWinner(input faultVec_t f);
    faultVec_t w;
    w = '0;
    if (f[IDX_OVP])       w[IDX_OVP]  = 1'b1;
    else if (f[IDX_HOT])  w[IDX_HOT]  = 1'b1;
    else if (f[IDX_SCP])  w[IDX_SCP]  = 1'b1;
    else if (f[IDX_OCP])  w[IDX_OCP]  = 1'b1;
    else if (f[IDX_OLP])  w[IDX_OLP]  = 1'b1;
    else if (f[IDX_WARM]) w[IDX_WARM] = 1'b1;
    return w;
  endfunction

endpackage

// File: rtl/fault_supervisor_dp.sv
module fault_supervisor_dp
  import fault_supervisor_pkg::*;
#(
  parameter int SCP_CYC        = 12,
  parameter int OCP_CYC        = 40,
  parameter int OLP_CYC        = 40,
  parameter int OVP_CYC        = 5,
  parameter int WARM_NORM_CYC  = 16,
  parameter int WARM_GREEN_CYC = 48,
  parameter int HOT_NORM_CYC   = 4,
  parameter int HOT_GREEN_CYC  = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  strobe,
  input  logic       senseOverLimit,
  input  logic       vddBelowScp,
  input  logic       vddOverVolt,
  input  logic       fbOpenLoop,
  input  logic       rtBelowWarm,
  input  logic       rtBelowHot,
  output faultVec_t  fireVec
);

  localparam int NUM_CHAN = 4;
  localparam int MAX_LIM = maxOf(maxOf(maxOf(OCP_CYC, OLP_CYC), maxOf(OVP_CYC, SCP_CYC)),
                                 maxOf(maxOf(WARM_NORM_CYC, WARM_GREEN_CYC),
                                       maxOf(HOT_NORM_CYC, HOT_GREEN_CYC)));
  localparam int CNT_W = $clog2(MAX_LIM + 1);
  // channel order: 0 OLP, 1 OVP, 2 warm, 3 hot
  localparam int NORM_LIM  [NUM_CHAN] = '{OLP_CYC, OVP_CYC, WARM_NORM_CYC,  HOT_NORM_CYC};
  localparam int GREEN_LIM [NUM_CHAN] = '{OLP_CYC, OVP_CYC, WARM_GREEN_CYC, HOT_GREEN_CYC};

  logic [NUM_CHAN-1:0] chanFlag;
  logic [NUM_CHAN-1:0] chanFire;

  assign chanFlag = {rtBelowHot, rtBelowWarm & ~rtBelowHot, vddOverVolt, fbOpenLoop};

  for (genvar g = 0; g < NUM_CHAN; g++) begin : g_chan
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;
    logic             active;

    assign lim         = strobe.greenSel ? CNT_W'(GREEN_LIM[g] - 1) : CNT_W'(NORM_LIM[g] - 1);
    assign active      = strobe.countEn & chanFlag[g];
    assign chanFire[g] = active & (cnt >= lim);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                       cnt <= '0;
      else if (active && !chanFire[g]) cnt <= cnt + CNT_W'(1);
      else                             cnt <= '0;
    end
  end

  // shared sense counter: one short-circuit decision point, then overcurrent end
  logic [CNT_W-1:0] senseCnt;
  logic             senseActive;
  logic             scpFire;
  logic             ocpFire;

  assign senseActive = strobe.countEn & senseOverLimit;
  assign scpFire     = senseActive & vddBelowScp & (senseCnt == CNT_W'(SCP_CYC - 1));
  assign ocpFire     = senseActive & (senseCnt >= CNT_W'(OCP_CYC - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  senseCnt <= '0;
    else if (senseActive && !scpFire && !ocpFire) senseCnt <= senseCnt + CNT_W'(1);
    else                                        senseCnt <= '0;
  end

  always_comb begin
    fireVec           = '0;
    fireVec[IDX_SCP]  = scpFire;
    fireVec[IDX_OCP]  = ocpFire;
    fireVec[IDX_OLP]  = chanFire[0];
    fireVec[IDX_OVP]  = chanFire[1];
    fireVec[IDX_WARM] = chanFire[2];
    fireVec[IDX_HOT]  = chanFire[3];
  end

endmodule

// File: rtl/fault_supervisor_ctl.sv
module fault_supervisor_ctl
  import fault_supervisor_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      vddAboveStart,
  input  logic      vddBelowStop,
  input  logic      vddBelowRelease,
  input  logic      greenMode,
  input  faultVec_t fireVec,
  output dpStrobe_t strobe,
  output logic      pwmEnable,
  output logic      faultLatched,
  output faultVec_t faultCode
);

  logic      runOn;
  faultVec_t latchCode;
  logic      isLatched;

  assign isLatched = |latchCode;

  // start/stop hysteresis
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        runOn <= 1'b0;
    else if (runOn && vddBelowStop)   runOn <= 1'b0;
    else if (!runOn && vddAboveStart) runOn <= 1'b1;
  end

  // shared protection latch with cause record
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchCode <= '0;
    end else if (isLatched) begin
      if (vddBelowRelease) latchCode <= '0;
    end else if (|fireVec) begin
      latchCode <= pickWinner(fireVec);
    end
  end

  assign strobe.countEn  = runOn & ~isLatched;
  assign strobe.greenSel = greenMode;
  assign pwmEnable       = runOn & ~isLatched;
  assign faultLatched    = isLatched;
  assign faultCode       = latchCode;

endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
  import fault_supervisor_pkg::*;
#(
  parameter int SCP_CYC        = 12,
  parameter int OCP_CYC        = 40,
  parameter int OLP_CYC        = 40,
  parameter int OVP_CYC        = 5,
  parameter int WARM_NORM_CYC  = 16,
  parameter int WARM_GREEN_CYC = 48,
  parameter int HOT_NORM_CYC   = 4,
  parameter int HOT_GREEN_CYC  = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       senseOverLimit,
  input  logic       vddBelowScp,
  input  logic       vddOverVolt,
  input  logic       fbOpenLoop,
  input  logic       rtBelowWarm,
  input  logic       rtBelowHot,
  input  logic       vddAboveStart,
  input  logic       vddBelowStop,
  input  logic       vddBelowRelease,
  input  logic       greenMode,
  output logic       pwmEnable,
  output logic       faultLatched,
  output logic [5:0] faultCode
);

  dpStrobe_t strobe;
  faultVec_t fireVec;
  faultVec_t codeInt;

  fault_supervisor_dp #(
    .SCP_CYC(SCP_CYC), .OCP_CYC(OCP_CYC), .OLP_CYC(OLP_CYC), .OVP_CYC(OVP_CYC),
    .WARM_NORM_CYC(WARM_NORM_CYC), .WARM_GREEN_CYC(WARM_GREEN_CYC),
    .HOT_NORM_CYC(HOT_NORM_CYC), .HOT_GREEN_CYC(HOT_GREEN_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .senseOverLimit(senseOverLimit), .vddBelowScp(vddBelowScp),
    .vddOverVolt(vddOverVolt), .fbOpenLoop(fbOpenLoop),
    .rtBelowWarm(rtBelowWarm), .rtBelowHot(rtBelowHot),
    .fireVec(fireVec)
  );

  fault_supervisor_ctl u_ctl (
    .clk(clk), .rstN(rstN),
    .vddAboveStart(vddAboveStart), .vddBelowStop(vddBelowStop),
    .vddBelowRelease(vddBelowRelease), .greenMode(greenMode),
    .fireVec(fireVec), .strobe(strobe),
    .pwmEnable(pwmEnable), .faultLatched(faultLatched), .faultCode(codeInt)
  );

  assign faultCode = codeInt;

endmodule

// File: rtl/fault_supervisor_chk.sv
module fault_supervisor_chk #(
  parameter int OVP_CYC = 5
) (
  input logic       clk,
  input logic       rstN,
  input logic       vddOverVolt,
  input logic       vddBelowStop,
  input logic       vddBelowRelease,
  input logic       pwmEnable,
  input logic       faultLatched,
  input logic [5:0] faultCode
);

  logic [15:0] ovpRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           ovpRun <= '0;
    else if (vddOverVolt && pwmEnable)   ovpRun <= ovpRun + 16'd1;
    else                                 ovpRun <= '0;
  end

  a_r10_code_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(faultCode) && (faultLatched == (faultCode != 6'd0)));

  a_r10_gate_off: assert property (@(posedge clk) disable iff (!rstN)
    faultLatched |-> !pwmEnable);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    (faultLatched && !vddBelowRelease) |=> (faultLatched && $stable(faultCode)));

  a_r11_release: assert property (@(posedge clk) disable iff (!rstN)
    (faultLatched && vddBelowRelease) |=> !faultLatched);

  a_r2_stop: assert property (@(posedge clk) disable iff (!rstN)
    (pwmEnable && vddBelowStop) |=> !pwmEnable);

  a_r13_idle_no_set: assert property (@(posedge clk) disable iff (!rstN)
    (!pwmEnable && !faultLatched) |=> !faultLatched);

  a_r7_ovp_window: assert property (@(posedge clk) disable iff (!rstN)
    (vddOverVolt && pwmEnable && ovpRun == 16'(OVP_CYC - 1)) |=> faultLatched);

endmodule

bind fault_supervisor fault_supervisor_chk #(.OVP_CYC(OVP_CYC)) u_chk (
  .clk(clk), .rstN(rstN), .vddOverVolt(vddOverVolt), .vddBelowStop(vddBelowStop),
  .vddBelowRelease(vddBelowRelease), .pwmEnable(pwmEnable),
  .faultLatched(faultLatched), .faultCode(faultCode)
);

// File: tb/fault_supervisor_tb.sv
`timescale 1ns/1ps
module fault_supervisor_tb;

  localparam int SCP  = 12, OCP = 40, OLP = 40, OVP = 5;
  localparam int WN   = 16, WG  = 48, HN  = 4,  HG  = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sense = 0, scpLow = 0, ovp = 0, olp = 0, warm = 0, hot = 0;
  logic start = 0, stop = 0, rel = 0, green = 0;
  logic pwmEnable, faultLatched;
  logic [5:0] faultCode;

  int compared = 0, mismatched = 0;
  bit done = 0;
  string curReq = "R1";

  always #2 clk = ~clk;

  fault_supervisor #(
    .SCP_CYC(SCP), .OCP_CYC(OCP), .OLP_CYC(OLP), .OVP_CYC(OVP),
    .WARM_NORM_CYC(WN), .WARM_GREEN_CYC(WG), .HOT_NORM_CYC(HN), .HOT_GREEN_CYC(HG)
  ) u_dut (
    .clk(clk), .rstN(rstN), .senseOverLimit(sense), .vddBelowScp(scpLow),
    .vddOverVolt(ovp), .fbOpenLoop(olp), .rtBelowWarm(warm), .rtBelowHot(hot),
    .vddAboveStart(start), .vddBelowStop(stop), .vddBelowRelease(rel),
    .greenMode(green), .pwmEnable(pwmEnable), .faultLatched(faultLatched),
    .faultCode(faultCode)
  );

  // behavioural reference: run lengths, run flag, latched cause
  bit mOn;
  logic [5:0] mCode;
  int rSense, rOlp, rOvp, rWarm, rHot;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mOn = 0; mCode = 0; rSense = 0; rOlp = 0; rOvp = 0; rWarm = 0; rHot = 0;
    end else begin
      bit armed;
      logic [5:0] f;
      armed  = mOn && (mCode == 0);
      rSense = (armed && sense) ? rSense + 1 : 0;
      rOlp   = (armed && olp) ? rOlp + 1 : 0;
      rOvp   = (armed && ovp) ? rOvp + 1 : 0;
      rWarm  = (armed && warm && !hot) ? rWarm + 1 : 0;
      rHot   = (armed && hot) ? rHot + 1 : 0;
      f = 0;
      if (rSense == SCP && scpLow) f[0] = 1;
      if (rSense >= OCP) f[1] = 1;
      if (rOlp >= OLP) f[2] = 1;
      if (rOvp >= OVP) f[3] = 1;
      if (rWarm > 0 && rWarm >= (green ? WG : WN)) f[4] = 1;
      if (rHot > 0 && rHot >= (green ? HG : HN)) f[5] = 1;
      if (f != 0) begin rSense = 0; rOlp = 0; rOvp = 0; rWarm = 0; rHot = 0; end
      if (mCode != 0) begin
        if (rel) mCode = 0;
      end else if (f[3]) mCode = 6'b001000;
      else if (f[5]) mCode = 6'b100000;
      else if (f[0]) mCode = 6'b000001;
      else if (f[1]) mCode = 6'b000010;
      else if (f[2]) mCode = 6'b000100;
      else if (f[4]) mCode = 6'b010000;
      if (mOn && stop) mOn = 0;
      else if (!mOn && start) mOn = 1;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      bit ePwm;
      ePwm = mOn && (mCode == 0);
      compared++;
      if (pwmEnable !== ePwm || faultLatched !== (mCode != 0) || faultCode !== mCode) begin
        mismatched++;
        $display("FAIL %s per-cycle: actual pwm=%b lat=%b code=%b expected pwm=%b lat=%b code=%b",
                 curReq, pwmEnable, faultLatched, faultCode, ePwm, (mCode != 0), mCode);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pcheck(input string tag, input logic [5:0] act, input logic [5:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic clearRelease();
    sense = 0; scpLow = 0; ovp = 0; olp = 0; warm = 0; hot = 0; green = 0;
    rel = 1; cyc(1); rel = 0; cyc(1);
  endtask

  initial begin
    repeat (8000) @(posedge clk);
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    cyc(3);
    curReq = "R1";
    pcheck("R1 reset outputs", {pwmEnable, faultLatched, faultCode[3:0]}, 6'b0);
    rstN = 1;

    curReq = "R13";
    ovp = 1; olp = 1; hot = 1; sense = 1; cyc(60);
    pcheck("R13 no latch while stopped", {5'b0, faultLatched}, 6'b0);
    ovp = 0; olp = 0; hot = 0; sense = 0; cyc(1);

    curReq = "R2";
    start = 1; cyc(1); start = 0;
    pcheck("R2 enable after start", {5'b0, pwmEnable}, 6'd1);
    cyc(5); pcheck("R2 hold", {5'b0, pwmEnable}, 6'd1);
    stop = 1; cyc(1); stop = 0;
    pcheck("R2 stop", {5'b0, pwmEnable}, 6'd0);
    start = 1; cyc(1); start = 0;
    pcheck("R2 restart", {5'b0, pwmEnable}, 6'd1);

    curReq = "R7";
    ovp = 1; cyc(4); pcheck("R7 before limit", {5'b0, faultLatched}, 6'd0);
    cyc(1); pcheck("R7 OVP code", faultCode, 6'b001000);

    curReq = "R10";
    olp = 1; hot = 1; sense = 1; scpLow = 1; cyc(50);
    pcheck("R10 code held", faultCode, 6'b001000);
    pcheck("R10 pwm off", {5'b0, pwmEnable}, 6'd0);
    sense = 0; scpLow = 0; ovp = 0; olp = 0; hot = 0; cyc(1);

    curReq = "R11";
    rel = 1; cyc(1); rel = 0;
    pcheck("R11 release clears", {faultLatched, faultCode[4:0]}, 6'd0);
    rel = 1; cyc(2); rel = 0;
    pcheck("R11 release unlatched no effect", {5'b0, pwmEnable}, 6'd1);

    curReq = "R5";
    ovp = 1; cyc(4); ovp = 0; cyc(1); ovp = 1; cyc(4); ovp = 0; cyc(1);
    pcheck("R5 OVP restart", {5'b0, faultLatched}, 6'd0);
    scpLow = 1;
    sense = 1; cyc(11); sense = 0; cyc(1); sense = 1; cyc(11);
    pcheck("R5 sense restart", {5'b0, faultLatched}, 6'd0);

    curReq = "R3";
    cyc(1); pcheck("R3 SCP code", faultCode, 6'b000001);
    clearRelease();
    scpLow = 1; sense = 1; cyc(11);
    pcheck("R3 before check", {5'b0, faultLatched}, 6'd0);
    cyc(1); pcheck("R3 SCP at check", faultCode, 6'b000001);
    clearRelease();

    curReq = "R4";
    scpLow = 1; sense = 1; cyc(11); scpLow = 0; cyc(1); scpLow = 1;
    pcheck("R4 no SCP when high at check", {5'b0, faultLatched}, 6'd0);
    cyc(27); pcheck("R4 before OCP limit", {5'b0, faultLatched}, 6'd0);
    cyc(1); pcheck("R4 OCP code", faultCode, 6'b000010);
    clearRelease();

    curReq = "R6";
    olp = 1; cyc(39); pcheck("R6 before limit", {5'b0, faultLatched}, 6'd0);
    cyc(1); pcheck("R6 OLP code", faultCode, 6'b000100);
    clearRelease();

    curReq = "R8";
    warm = 1; cyc(15); pcheck("R8 normal before", {5'b0, faultLatched}, 6'd0);
    cyc(1); pcheck("R8 normal code", faultCode, 6'b010000);
    clearRelease();
    green = 1; warm = 1; cyc(47); pcheck("R8 green before", {5'b0, faultLatched}, 6'd0);
    cyc(1); pcheck("R8 green code", faultCode, 6'b010000);
    clearRelease();
    green = 1; warm = 1; cyc(20); pcheck("R8 past normal in green", {5'b0, faultLatched}, 6'd0);
    green = 0; cyc(1); pcheck("R8 mode drop fires", faultCode, 6'b010000);
    clearRelease();

    curReq = "R9";
    warm = 1; hot = 1; cyc(3); pcheck("R9 normal before", {5'b0, faultLatched}, 6'd0);
    cyc(1); pcheck("R9 hot normal code", faultCode, 6'b100000);
    clearRelease();
    green = 1; hot = 1; cyc(11); pcheck("R9 green before", {5'b0, faultLatched}, 6'd0);
    cyc(1); pcheck("R9 hot green code", faultCode, 6'b100000);
    clearRelease();

    curReq = "R12";
    green = 1; hot = 1; sense = 1; scpLow = 1; cyc(12);
    pcheck("R12 hot over SCP", faultCode, 6'b100000);
    clearRelease();
    sense = 1; olp = 1; cyc(40);
    pcheck("R12 OCP over OLP", faultCode, 6'b000010);
    clearRelease();

    cyc(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule